// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a single-entry internal request port to an external 128K x 8 asynchronous static RAM. It drives the 17-bit address, a pair of chip selects (one active-low, one active-high), an active-low write strobe and an active-low read strobe. The data bus is split into an outbound byte, an inbound byte and a drive enable for the pad's tri-state buffer. Every cycle length is counted in system clocks. The counts are derived from nanosecond parameters, so one set of parameters covers one memory speed grade and one clock period.

A client presents a request (valid, write flag, address, write byte) while `req_ready` is high. A read returns its byte on `rd_data` together with a one-clock `rd_done` pulse. A write returns nothing. A standby input, taken only between cycles, parks the memory in its low-power deselected state.

The controller is a seven-state machine. **IDLE** is deselected and ready. It moves to **SLEEP** on standby, to **RACC** on a read, to **WSETUP** on a write, or to **TURN** on a write that arrives while the bus turnaround window is still open. **RACC** holds the read strobe low for the access count and then returns to IDLE, capturing the data as it leaves. **TURN** waits for the turnaround counter and then moves to **WSETUP**. **WSETUP** drives address and data with the write strobe high for one clock and then moves to **WPULSE**. **WPULSE** holds the write strobe low for the pulse count and then moves to **WHOLD**. **WHOLD** raises the write strobe, keeps driving the data for one clock and then returns to IDLE. **SLEEP** returns to IDLE when standby is released.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, both strobes are high, the bus driver is off, the selects are in the idle encoding, `req_ready` is 1, `rd_done` is 0 and `rd_data` is 0.
- R2: The selects use three encodings: during a memory cycle `mem_sel_n`=0 and `mem_sel`=1; when idle or turning around `mem_sel_n`=1 and `mem_sel`=1; in standby `mem_sel_n`=1 and `mem_sel`=0.
- R3: A read holds `mem_rd_n` low for exactly RD_CYC = ceil(T_ACC_NS/CLK_NS) clocks (9 by default), with `mem_wr_n` high the whole time. It captures `mem_dq_in` at the last of those clocks and presents it on `rd_data`.
- R4: A write spends one setup clock with data driven and `mem_wr_n` high, then holds `mem_wr_n` low for exactly WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-2) clocks (7 by default), then spends one hold clock with data still driven and `mem_wr_n` high. `mem_rd_n` stays high throughout, and the byte is stored at the requested address.
- R5: `mem_addr` never changes while the memory is selected, and `mem_dq_out` never changes while the driver is on. Changes on the request inputs during a cycle have no effect on the cycle.
- R6: The bus driver is never on while `mem_rd_n` is low. After `mem_rd_n` rises, the driver stays off for at least TA_CYC+1 clocks, where TA_CYC = ceil(T_HZ_NS/CLK_NS) (4 by default).
- R7: `req_ready` is 0 from the clock after acceptance until the cycle returns to IDLE, and no request is taken while it is 0.
- R8: Standby is honoured in IDLE and wins over a request in the same clock. While in standby, the selects are in the standby encoding, both strobes are high and the driver is off. Release returns the block to IDLE and normal service.
- R9: Standby raised during a read does not shorten or abort it. The read completes with correct data, and standby takes effect one clock after the block returns to IDLE.
- R10: `rd_done` is high for exactly one clock per read. `rd_data` holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request may be accepted this clock |
| rd_done | output | 1 | One-clock pulse: read data valid |
| rd_data | output | 8 | Registered read byte |
| standby_req | input | 1 | Request low-power deselect |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output (read) strobe |
| mem_dq_out | output | 8 | Byte toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pad buffer |
| mem_dq_in | input | 8 | Byte from the memory |

## Verification
Two pairs of functions can fall in the same clock. The first is a standby request and a new transfer request arriving together while the block is idle. The bench raises both in one clock and expects standby to win: no strobe moves, no byte is stored, and the held write runs only after release. The second is a standby arriving while a read is in progress. The bench judges this by the full strobe length, the correct returned byte and standby taking hold only after the read completes. A write issued straight after a read is the third collision: the turnaround window and the driver enable compete, and a bus monitor times the gap between them.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RACC   = 3'd1,
        ST_TURN   = 3'd2,
        ST_WSETUP = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5,
        ST_SLEEP  = 3'd6
    } asram_state_e;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_downcnt.sv
module asram_downcnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned WP_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             standby_req,
    input  logic             tmr_zero,
    input  logic             ta_zero,
    output asram_state_e     state_q,
    output asram_state_e     state_d,
    output logic             accept,
    output logic             req_ready,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ta_load
);
    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE) && !standby_req;
    assign accept    = req_ready && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (standby_req) begin
                    state_d = ST_SLEEP;
                end else if (req_valid) begin
                    if (req_write) begin
                        state_d = ta_zero ? ST_WSETUP : ST_TURN;
                    end else begin
                        state_d = ST_RACC;
                    end
                end
            end
            ST_RACC:   if (tmr_zero) state_d = ST_IDLE;
            ST_TURN:   if (ta_zero)  state_d = ST_WSETUP;
            ST_WSETUP: state_d = ST_WPULSE;
            ST_WPULSE: if (tmr_zero) state_d = ST_WHOLD;
            ST_WHOLD:  state_d = ST_IDLE;
            ST_SLEEP:  if (!standby_req) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // cycle timer loads on entry to a timed state
    assign tmr_load = (state_d != state_q) &&
                      ((state_d == ST_RACC) || (state_d == ST_WPULSE));
    assign tmr_val  = (state_d == ST_RACC) ? CNT_W'(RD_CYC - 1) : CNT_W'(WP_CYC - 1);

    // turnaround window opens when the read strobe is released
    assign ta_load  = (state_q == ST_RACC) && (state_d == ST_IDLE);
endmodule

// File: rtl/asram_pins.sv
module asram_pins
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asram_state_e      state_q,
    input  asram_state_e      state_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);
    logic capture;
    assign capture = (state_q == ST_RACC) && (state_d == ST_IDLE);

    // output register process: pins follow the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_sel_n  <= 1'b1;
            mem_sel    <= 1'b1;
            mem_wr_n   <= 1'b1;
            mem_rd_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            rd_data    <= '0;
            rd_done    <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            rd_done <= capture;
            if (capture) begin
                rd_data <= mem_dq_in;
            end
            unique case (state_d)
                ST_IDLE, ST_TURN: begin
                    mem_sel_n <= 1'b1; mem_sel <= 1'b1;
                    mem_wr_n  <= 1'b1; mem_rd_n <= 1'b1; mem_dq_oe <= 1'b0;
                end
                ST_SLEEP: begin
                    mem_sel_n <= 1'b1; mem_sel <= 1'b0;
                    mem_wr_n  <= 1'b1; mem_rd_n <= 1'b1; mem_dq_oe <= 1'b0;
                end
                ST_RACC: begin
                    mem_sel_n <= 1'b0; mem_sel <= 1'b1;
                    mem_wr_n  <= 1'b1; mem_rd_n <= 1'b0; mem_dq_oe <= 1'b0;
                end
                ST_WSETUP, ST_WHOLD: begin
                    mem_sel_n <= 1'b0; mem_sel <= 1'b1;
                    mem_wr_n  <= 1'b1; mem_rd_n <= 1'b1; mem_dq_oe <= 1'b1;
                end
                ST_WPULSE: begin
                    mem_sel_n <= 1'b0; mem_sel <= 1'b1;
                    mem_wr_n  <= 1'b0; mem_rd_n <= 1'b1; mem_dq_oe <= 1'b1;
                end
                default: begin
                    mem_sel_n <= 1'b1; mem_sel <= 1'b1;
                    mem_wr_n  <= 1'b1; mem_rd_n <= 1'b1; mem_dq_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_ACC_NS  = 70,
    parameter int unsigned T_WP_NS   = 50,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_HZ_NS   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              standby_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC = umax(cdiv(T_ACC_NS, CLK_NS), 1);
    localparam int unsigned WP_CYC = umax(umax(cdiv(T_WP_NS, CLK_NS), 1),
                                          (cdiv(T_WC_NS, CLK_NS) > 2) ?
                                          cdiv(T_WC_NS, CLK_NS) - 2 : 1);
    localparam int unsigned TA_CYC = cdiv(T_HZ_NS, CLK_NS);
    localparam int unsigned CNT_W  = $clog2(umax(umax(RD_CYC, WP_CYC), TA_CYC) + 1);

    asram_state_e     state_q, state_d;
    logic             accept, tmr_load, tmr_zero, ta_load, ta_zero;
    logic [CNT_W-1:0] tmr_val;

    asram_fsm #(
        .CNT_W (CNT_W),
        .RD_CYC(RD_CYC),
        .WP_CYC(WP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .standby_req(standby_req),
        .tmr_zero   (tmr_zero),
        .ta_zero    (ta_zero),
        .state_q    (state_q),
        .state_d    (state_d),
        .accept     (accept),
        .req_ready  (req_ready),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ta_load    (ta_load)
    );

    asram_downcnt #(.W(CNT_W)) u_cyc_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .is_zero (tmr_zero)
    );

    generate
        if (TA_CYC > 0) begin : g_turn
            asram_downcnt #(.W(CNT_W)) u_ta_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (ta_load),
                .load_val(CNT_W'(TA_CYC)),
                .is_zero (ta_zero)
            );
        end else begin : g_no_turn
            assign ta_zero = 1'b1;
        end
    endgenerate

    asram_pins #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .state_d   (state_d),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_wr_n  (mem_wr_n),
        .mem_rd_n  (mem_rd_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .rd_data   (rd_data),
        .rd_done   (rd_done)
    );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    // R4
    wr_strobe_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_rd_n && mem_dq_oe && !mem_sel_n && mem_sel));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dq_oe);

    // R6
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |=> !mem_dq_oe);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R8
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel |-> (mem_sel_n && mem_rd_n && mem_wr_n && !mem_dq_oe));

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n |-> !req_ready);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_done   (rd_done),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
    localparam int BN_RD = (70 + 8 - 1) / 8;   // 9
    localparam int BN_WP = (50 + 8 - 1) / 8;   // 7
    localparam int BN_TA = (25 + 8 - 1) / 8;   // 4

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_done;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int n_vec = 0, n_bad = 0, viol = 0;
    bit finished = 0;
    time rise_t = 0;

    always #4 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_done(rd_done), .rd_data(rd_data), .standby_req(standby_req),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem [int];
    int         rcnt = 0;
    logic       mdrive;

    function automatic logic [7:0] mem_rd(input logic [16:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'hA5;
    endfunction

    assign mdrive    = !mem_sel_n && mem_sel && mem_wr_n && !mem_rd_n;
    assign mem_dq_in = (mdrive && rcnt >= BN_RD - 1) ? mem_rd(mem_addr) : 8'hEE;

    always @(posedge clk) rcnt <= mdrive ? rcnt + 1 : 0;

    logic [16:0] p_addr = '0;
    logic        p_sel_n = 1'b1, p_rd_n = 1'b1, pend = 1'b0;
    logic [16:0] pend_a = '0;
    logic [7:0]  pend_d = '0;
    int          hz = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && mdrive) begin
                viol++; $display("bus clash at %0t", $time);
            end
            if (!p_rd_n && mem_rd_n) begin
                hz = BN_TA; rise_t = $time;
            end else if (hz > 0) hz--;
            if (hz > 0 && mem_dq_oe) begin
                viol++; $display("turnaround too short at %0t", $time);
            end
            if (!mem_sel_n && !p_sel_n && mem_addr != p_addr) begin
                viol++; $display("address moved while selected at %0t", $time);
            end
            if (!mem_wr_n && !mem_sel_n && mem_sel) begin
                if (!mem_dq_oe) begin
                    viol++; $display("write strobe without data at %0t", $time);
                end
                pend = 1'b1; pend_a = mem_addr; pend_d = mem_dq_out;
            end else if (mem_wr_n && pend) begin
                mem[int'(pend_a)] = pend_d; pend = 1'b0;
            end
            p_addr = mem_addr; p_sel_n = mem_sel_n; p_rd_n = mem_rd_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit after_read);
        int wl = 0, held = 0, guard = 0;
        bit first = 1'b1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk("R7 ready low after write accept", req_ready, 0);
        while (!req_ready && guard < 200) begin
            if (!mem_wr_n) wl++;
            if (mem_dq_oe && mem_wr_n) held++;
            if (mem_dq_oe && first) begin
                first = 1'b0;
                if (after_read)
                    chk("R6 driver gap after read", (($time - rise_t) / 8) >= BN_TA + 1, 1);
            end
            if (!mem_rd_n) chk("R4 read strobe during write", mem_rd_n, 1);
            @(negedge clk); guard++;
        end
        chk("R4 write pulse clocks", wl, BN_WP);
        chk("R4 setup+hold driven clocks", held, 2);
        chk("R4 byte stored", mem_rd(a), d);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input bit sb_mid);
        int rl = 0, guard = 0;
        bit sel_ok = 1'b1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        chk("R7 ready low after read accept", req_ready, 0);
        if (sb_mid) standby_req = 1'b1;
        while (!rd_done && guard < 200) begin
            if (!mem_rd_n) begin
                rl++;
                if (mem_sel_n || !mem_sel || !mem_wr_n) sel_ok = 1'b0;
            end
            @(negedge clk); guard++;
        end
        chk("R3 read strobe clocks", rl, BN_RD);
        chk("R2 cycle select encoding", sel_ok, 1);
        chk("R3 read data", rd_data, exp);
        chk("R10 done high", rd_done, 1);
        @(negedge clk);
        chk("R10 done single clock", rd_done, 0);
        chk("R10 data held", rd_data, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 wr strobe", mem_wr_n, 1);
        chk("R1 rd strobe", mem_rd_n, 1);
        chk("R1 driver off", mem_dq_oe, 0);
        chk("R1 idle select", {mem_sel_n, mem_sel}, 2'b11);
        chk("R1 ready", req_ready, 1);
        chk("R1 done", rd_done, 0);
        chk("R1 data", rd_data, 0);
    endtask

    task automatic t_patterns();
        do_write(17'h00000, 8'h00, 1'b0);
        do_write(17'h1FFFF, 8'hFF, 1'b0);
        do_write(17'h0AAAA, 8'h5A, 1'b0);
        do_read(17'h1FFFF, 8'hFF, 1'b0);
        do_read(17'h00000, 8'h00, 1'b0);
        do_read(17'h0AAAA, 8'h5A, 1'b0);
        chk("R2 idle select", {mem_sel_n, mem_sel}, 2'b11);
    endtask

    task automatic t_turnaround();
        do_read(17'h0AAAA, 8'h5A, 1'b0);
        do_write(17'h15555, 8'hC3, 1'b1);
        do_read(17'h15555, 8'hC3, 1'b0);
        chk("R6 R5 bus monitor clean", viol, 0);
    endtask

    task automatic t_standby_vs_req();
        while (!req_ready) @(negedge clk);
        standby_req = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        req_addr = 17'h00123; req_wdata = 8'h3C;
        @(negedge clk);
        chk("R8 standby select", {mem_sel_n, mem_sel}, 2'b10);
        chk("R8 ready low in standby", req_ready, 0);
        chk("R8 strobes idle", {mem_wr_n, mem_rd_n, mem_dq_oe}, 3'b110);
        repeat (5) @(negedge clk);
        chk("R8 request held off", mem.exists(32'h123), 0);
        chk("R8 still standby", mem_sel, 0);
        standby_req = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R8 release to idle", {mem_sel_n, mem_sel, req_ready}, 3'b111);
        do_write(17'h00123, 8'h3C, 1'b0);
        do_read(17'h00123, 8'h3C, 1'b0);
    endtask

    task automatic t_standby_mid_read();
        do_read(17'h00000, 8'h00, 1'b1);
        chk("R9 standby after read", {mem_sel_n, mem_sel}, 2'b10);
        standby_req = 1'b0;
        @(negedge clk);
        chk("R9 back to idle", req_ready, 1);
        do_write(17'h00001, 8'h81, 1'b0);
        chk("R10 data held across write", rd_data, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_turnaround();
        t_standby_vs_req();
        t_standby_mid_read();
        chk("R5 R6 monitor final", viol, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule